// File: doc/BRIEF.md
# Peripheral Clock Source Selector

This block sits between a bank of upstream clock generators and six internal peripheral consumers. Each upstream source (an auxiliary PLL and six programmable dividers) arrives as a single-cycle clock-enable pulse train in the system clock domain. For every consumer the block picks one of those trains or none, then thins it by a fixed post-divide ratio. The result is a per-consumer output enable.

All six consumers are programmed through one shared 32-bit control word that software writes in a single cycle and can read back. Each consumer owns a 5-bit field holding a 3-bit source select and a 2-bit ratio code. A select of zero switches the consumer off. The ratio code follows a non-monotonic table. A build parameter picks an extended variant in which one code yields a divide-by-3.

A new field value is visible on read-back at once. A consumer adopts it only when its post-divide count sits at a period boundary, so a consumer never emits a shortened or stretched period.

Top module: `pcs_top`

## Requirements
- R1: After reset the control word reads zero. A write stores the data and it reads back on `cfg_rd_data` from the next cycle. Bits 31:30 are unused and always read as zero.
- R2: Consumer i owns bits 5*i+4 down to 5*i of the control word. Within that field, bits 4:2 are the source select and bits 1:0 are the ratio code.
- R3: A consumer whose applied source select is 0 keeps its output enable low and its post-divide count cleared, whatever the source pulses do.
- R4: Source select 1 routes `aux_ce`. Source select 2+k (k = 0..5) routes `div_ce[k]`.
- R5: In the base variant the ratio code maps 0 to divide-by-1, 1 to divide-by-4, 2 to divide-by-1 and 3 to divide-by-2. A consumer's output enable is registered and rises one cycle after the source pulse that completes a period.
- R6: In the extended variant (`EXT_DIV3` = 1), ratio code 2 gives divide-by-3. The other codes are unchanged.
- R7: `cons_on[i]` is high exactly when the stored source select of consumer i is nonzero. It follows a write from the next cycle.
- R8: A consumer adopts a new select or ratio code only in a cycle whose post-divide count is about to return to zero. Pulses already counted in the running period complete under the old setting.
- R9: Under divide-by-N (N = 2, 3 or 4), a consumer emits one single-cycle output enable for every N selected source pulses, on the Nth pulse of each period. Under divide-by-1 the output repeats every selected pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the control word |
| cfg_wr_data | input | 32 | Control word write data |
| cfg_rd_data | output | 32 | Control word read-back |
| aux_ce | input | 1 | Auxiliary PLL enable pulse train |
| div_ce | input | 6 | Upstream divider enable pulse trains |
| cons_ce | output | 6 | Per-consumer divided output enable |
| cons_on | output | 6 | Per-consumer enabled indication |

## Verification
A wrong applied select shows at the consumer's output enable within one cycle of the next pulse on either the intended or the wrongly chosen source. A stale or corrupted post-divide count shows as an early, late or missing output pulse within at most four source pulses. A configuration adopted mid-period misplaces the very next output pulse, so boundary errors show as soon as the period that was interrupted would have closed. Register and enable-flag faults show on `cfg_rd_data` and `cons_on` in the cycle after the offending write.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

   localparam int unsigned CODE_W = 2;
   localparam int unsigned CNT_W  = 2;
   localparam int unsigned RAT_W  = 3;

   // Ratio table shared by both variants; 'ext' turns code 2 into divide-by-3.
   function automatic logic [RAT_W-1:0] code_to_ratio(input logic [CODE_W-1:0] code,
                                                       input logic ext);
      logic [RAT_W-1:0] r;
      case (code)
         2'd0:    r = 3'd1;
         2'd1:    r = 3'd4;
         2'd2:    r = ext ? 3'd3 : 3'd1;
         default: r = 3'd2;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pcs_cfg_reg.sv
module pcs_cfg_reg #(
   parameter int unsigned REG_W  = 32,
   parameter int unsigned USED_W = 30
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] q
);

   localparam logic [REG_W-1:0] KEEP_MASK = ~({REG_W{1'b1}} << USED_W);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (wr_en) begin
         q <= wr_data & KEEP_MASK;
      end
   end

   // R1: contents change only on a write strobe
   a_r1_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(q));

endmodule

// File: rtl/pcs_src_mux.sv
module pcs_src_mux #(
   parameter int unsigned NUM_DIV = 6,
   parameter int unsigned SEL_W   = 3
) (
   input  logic [SEL_W-1:0]   sel,
   input  logic               aux_ce,
   input  logic [NUM_DIV-1:0] div_ce,
   output logic               src_ce
);

   localparam int unsigned NSLOT = 1 << SEL_W;
   localparam int unsigned NREAL = NUM_DIV + 2;

   logic [NSLOT-1:0] slots;

   // slot 0 = off, slot 1 = aux, slots 2.. = dividers, rest tied low
   generate
      if (NSLOT > NREAL) begin : g_pad
         assign slots = {{(NSLOT-NREAL){1'b0}}, div_ce, aux_ce, 1'b0};
      end else begin : g_full
         assign slots = {div_ce, aux_ce, 1'b0};
      end
   endgenerate

   assign src_ce = slots[sel];

endmodule

// File: rtl/pcs_post_div.sv
module pcs_post_div
   import pcs_pkg::*;
#(
   parameter bit          EXT_DIV3 = 1'b0,
   parameter int unsigned SEL_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  fld_sel,
   input  logic [CODE_W-1:0] fld_code,
   output logic [SEL_W-1:0]  act_sel,
   input  logic              src_ce,
   output logic              ce_out
);

   logic [CODE_W-1:0] act_code;
   logic [CNT_W-1:0]  cnt, cnt_nx;
   logic [RAT_W-1:0]  ratio;
   logic              running, period_end, boundary;

   generate
      if (EXT_DIV3) begin : g_ext
         assign ratio = code_to_ratio(act_code, 1'b1);
      end else begin : g_base
         assign ratio = code_to_ratio(act_code, 1'b0);
      end
   endgenerate

   assign running    = (act_sel != '0);
   assign period_end = ({1'b0, cnt} == (ratio - 3'd1));

   always_comb begin
      if (!running)      cnt_nx = '0;
      else if (!src_ce)  cnt_nx = cnt;
      else if (period_end) cnt_nx = '0;
      else               cnt_nx = cnt + 1'b1;
   end

   assign boundary = (cnt_nx == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_sel  <= '0;
         act_code <= '0;
         cnt      <= '0;
         ce_out   <= 1'b0;
      end else begin
         cnt    <= cnt_nx;
         ce_out <= running & src_ce & period_end;
         if (boundary) begin
            act_sel  <= fld_sel;
            act_code <= fld_code;
         end
      end
   end

   // R3: an idle consumer stays silent with a cleared count
   a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (act_sel == '0) |=> (!ce_out && cnt == '0));

   // R8: applied settings move only while the count rests at zero
   a_r8_switch_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(act_sel) || !$stable(act_code)) |-> (cnt == '0));

   // R9: count never reaches the ratio
   a_r9_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, cnt} < ratio));

   // R5: divide-by-1 passes the selected source through one cycle later
   a_r5_unity_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (running && ratio == 3'd1) |=> (ce_out == $past(src_ce)));

endmodule

// File: rtl/pcs_top.sv
module pcs_top
   import pcs_pkg::*;
#(
   parameter int unsigned NUM_CONS = 6,
   parameter int unsigned NUM_DIV  = 6,
   parameter int unsigned REG_W    = 32,
   parameter bit          EXT_DIV3 = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_wr_en,
   input  logic [REG_W-1:0]    cfg_wr_data,
   output logic [REG_W-1:0]    cfg_rd_data,
   input  logic                aux_ce,
   input  logic [NUM_DIV-1:0]  div_ce,
   output logic [NUM_CONS-1:0] cons_ce,
   output logic [NUM_CONS-1:0] cons_on
);

   localparam int unsigned SEL_W   = $clog2(NUM_DIV + 2);
   localparam int unsigned FIELD_W = SEL_W + CODE_W;
   localparam int unsigned USED_W  = NUM_CONS * FIELD_W;

   generate
      if (USED_W > REG_W) begin : g_chk_fit
         $error("pcs_top: consumer fields exceed control word width");
      end
      if (NUM_CONS < 1 || NUM_DIV < 1) begin : g_chk_cnt
         $error("pcs_top: need at least one consumer and one divider");
      end
   endgenerate

   logic [REG_W-1:0] cfg_q;

   pcs_cfg_reg #(
      .REG_W  (REG_W),
      .USED_W (USED_W)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr_en),
      .wr_data (cfg_wr_data),
      .q       (cfg_q)
   );

   assign cfg_rd_data = cfg_q;

   generate
      for (genvar i = 0; i < NUM_CONS; i++) begin : g_cons
         logic [FIELD_W-1:0] fld;
         logic [SEL_W-1:0]   act_sel;
         logic               src_ce;

         assign fld        = cfg_q[i*FIELD_W +: FIELD_W];
         assign cons_on[i] = (fld[FIELD_W-1:CODE_W] != '0);

         pcs_src_mux #(
            .NUM_DIV (NUM_DIV),
            .SEL_W   (SEL_W)
         ) u_mux (
            .sel    (act_sel),
            .aux_ce (aux_ce),
            .div_ce (div_ce),
            .src_ce (src_ce)
         );

         pcs_post_div #(
            .EXT_DIV3 (EXT_DIV3),
            .SEL_W    (SEL_W)
         ) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .fld_sel  (fld[FIELD_W-1:CODE_W]),
            .fld_code (fld[CODE_W-1:0]),
            .act_sel  (act_sel),
            .src_ce   (src_ce),
            .ce_out   (cons_ce[i])
         );
      end
   endgenerate

endmodule

// File: tb/tb_pcs_top.sv
module tb_pcs_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [31:0] cfg_wr_data = '0;
   logic        aux_ce = 1'b0;
   logic [5:0]  div_ce = '0;
   logic [31:0] rd_b, rd_x;
   logic [5:0]  ce_b, ce_x, on_b, on_x;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #2 clk = ~clk;

   pcs_top #(.EXT_DIV3(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
      .cfg_rd_data(rd_b), .aux_ce(aux_ce), .div_ce(div_ce), .cons_ce(ce_b), .cons_on(on_b));

   pcs_top #(.EXT_DIV3(1'b1)) dut_x (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
      .cfg_rd_data(rd_x), .aux_ce(aux_ce), .div_ce(div_ce), .cons_ce(ce_x), .cons_on(on_x));

   // reference model, index 0 = base variant, 1 = extended variant
   logic [31:0] m_reg;
   int          m_sel [2][6];
   int          m_code[2][6];
   int          m_cnt [2][6];
   logic [5:0]  m_out [2];

   function automatic int ratio_ref(int code, int ext);
      if (code == 1) return 4;
      if (code == 3) return 2;
      if (code == 2 && ext == 1) return 3;
      return 1;
   endfunction

   function automatic logic [5:0] on_ref(logic [31:0] r);
      logic [5:0] v;
      for (int i = 0; i < 6; i++) v[i] = (((r >> (5*i + 2)) & 32'h7) != 0);
      return v;
   endfunction

   task automatic model_reset();
      m_reg = '0;
      for (int v = 0; v < 2; v++) begin
         m_out[v] = '0;
         for (int i = 0; i < 6; i++) begin
            m_sel[v][i] = 0; m_code[v][i] = 0; m_cnt[v][i] = 0;
         end
      end
   endtask

   task automatic model_clock(input logic wr, input logic [31:0] wd,
                              input logic a, input logic [5:0] d);
      for (int v = 0; v < 2; v++) begin
         for (int i = 0; i < 6; i++) begin
            int n, nx;
            logic s;
            n = ratio_ref(m_code[v][i], v);
            if (m_sel[v][i] == 0)      s = 1'b0;
            else if (m_sel[v][i] == 1) s = a;
            else                       s = d[m_sel[v][i] - 2];
            m_out[v][i] = (m_sel[v][i] != 0) && s && (m_cnt[v][i] == n - 1);
            if (m_sel[v][i] == 0) nx = 0;
            else if (!s)          nx = m_cnt[v][i];
            else                  nx = (m_cnt[v][i] == n - 1) ? 0 : m_cnt[v][i] + 1;
            m_cnt[v][i] = nx;
            if (nx == 0) begin
               m_sel[v][i]  = int'((m_reg >> (5*i + 2)) & 32'h7);
               m_code[v][i] = int'((m_reg >> (5*i)) & 32'h3);
            end
         end
      end
      if (wr) m_reg = wd & 32'h3FFF_FFFF;
   endtask

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic check_all(input string tag);
      check({tag, " base cons_ce"}, {26'd0, ce_b}, {26'd0, m_out[0]});
      check({tag, " ext cons_ce"},  {26'd0, ce_x}, {26'd0, m_out[1]});
      check("R7 cons_on", {26'd0, on_b}, {26'd0, on_ref(m_reg)});
      check("R1 readback", rd_b, m_reg);
   endtask

   // called at a negedge; returns at the next negedge with outputs settled
   task automatic step(input string tag, input logic wr, input logic [31:0] wd,
                       input logic a, input logic [5:0] d);
      cfg_wr_en = wr; cfg_wr_data = wd; aux_ce = a; div_ce = d;
      @(posedge clk);
      model_clock(wr, wd, a, d);
      @(negedge clk);
      cfg_wr_en = 1'b0; aux_ce = 1'b0; div_ce = '0;
      check_all(tag);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int cnt_b, cnt_x;
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state, R3/R7 idle outputs
      check("R1 reset readback", rd_b, 32'h0);
      check("R3 reset cons_ce", {26'd0, ce_b}, 32'h0);
      check("R7 reset cons_on", {26'd0, on_b}, 32'h0);

      // R1 unused top bits read zero, R7 all consumers on
      step("R1", 1'b1, 32'hFFFF_FFFF, 1'b0, '0);
      check("R1 unused bits", rd_b, 32'h3FFF_FFFF);
      check("R1 ext readback", rd_x, 32'h3FFF_FFFF);
      check("R7 all on", {26'd0, on_x}, 32'h3F);

      // R3 disabled: pulses on every source, nothing out
      step("R3", 1'b1, 32'h0, 1'b0, '0);
      repeat (3) step("R3", 1'b0, 0, 1'b0, '0);
      for (int k = 0; k < 5; k++) begin
         step("R3", 1'b0, 0, 1'b1, 6'h3F);
         check("R3 disabled silent", {26'd0, ce_b | ce_x}, 32'h0);
      end

      // R4 consumer 0 on divider 1 (select 3 -> field 0x0C), divide-by-1
      step("R4", 1'b1, 32'h0000_000C, 1'b0, '0);
      step("R4", 1'b0, 0, 1'b0, '0);
      step("R4", 1'b0, 0, 1'b0, 6'b000010);
      check("R4 div1 routed", {31'd0, ce_b[0]}, 32'd1);
      step("R4", 1'b0, 0, 1'b1, 6'b111101);
      check("R4 other sources blocked", {31'd0, ce_b[0]}, 32'd0);

      // R2 consumer 5 on aux: select bits at 29:27 -> 1<<27
      step("R2", 1'b1, 32'h0800_0000, 1'b0, '0);
      check("R2 field position on", {26'd0, on_b}, 32'h20);
      step("R2", 1'b0, 0, 1'b0, '0);
      step("R2", 1'b0, 0, 1'b1, '0);
      check("R2 consumer5 output", {26'd0, ce_b}, 32'h20);

      // R6 consumer 0 on aux with code 2: base /1, extended /3
      step("R6", 1'b1, 32'h0000_0006, 1'b0, '0);
      step("R6", 1'b0, 0, 1'b0, '0);
      cnt_b = 0; cnt_x = 0;
      for (int k = 0; k < 6; k++) begin
         step("R6", 1'b0, 0, 1'b1, '0);
         cnt_b += ce_b[0];
         cnt_x += ce_x[0];
      end
      check("R5 code2 base is /1", cnt_b, 6);
      check("R6 code2 ext is /3", cnt_x, 2);

      // R8 /4 on aux, switch to /1 after two pulses
      step("R8", 1'b1, 32'h0000_0005, 1'b0, '0);
      step("R8", 1'b0, 0, 1'b0, '0);
      step("R8", 1'b0, 0, 1'b1, '0);
      step("R8", 1'b0, 0, 1'b1, '0);
      step("R8", 1'b1, 32'h0000_0004, 1'b0, '0);
      step("R8", 1'b0, 0, 1'b1, '0);
      check("R8 old period still running", {31'd0, ce_b[0]}, 32'd0);
      step("R8", 1'b0, 0, 1'b1, '0);
      check("R8 old period closes", {31'd0, ce_b[0]}, 32'd1);
      step("R8", 1'b0, 0, 1'b1, '0);
      check("R8 new ratio applied", {31'd0, ce_b[0]}, 32'd1);

      // R9 /2 on aux: alternate outputs
      step("R9", 1'b1, 32'h0000_0007, 1'b0, '0);
      step("R9", 1'b0, 0, 1'b0, '0);
      cnt_b = 0;
      for (int k = 0; k < 8; k++) begin
         step("R9", 1'b0, 0, 1'b1, '0);
         cnt_b += ce_b[0];
      end
      check("R9 div2 count", cnt_b, 4);

      // random mix
      for (int k = 0; k < 4000; k++) begin
         logic        wr;
         logic [31:0] wd;
         wr = ($urandom_range(0, 15) == 0);
         wd = $urandom();
         step("R5/R6/R8/R9 random", wr, wd, ($urandom_range(0, 2) != 0), 6'($urandom()));
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule